// File: doc/BRIEF.md
# Single-Wire Configuration Register Loader

This block takes configuration writes from a host over one shared, bidirectional data line and stores them in two 12-bit registers. One register carries operating-mode settings and the other carries the lower and upper timing limits. Each write is a serial frame of fifteen bits, sampled one per bit strobe: a zero start bit, a register-select bit, twelve data bits sent most significant first, and a zero stop bit. The stored values leave the block as parallel words for the decoders around it.

A supply-loss flag is set by power-on reset or by a brown-out request. Any of these events restores both registers to their default values. While the flag is set and no frame is in progress, the block signals the loss to the host. It does this by pulling the line low in a repeating pattern, using a drive-enable output. The first frame that is committed clears the flag and ends the pattern.

The controller has six states. In ST_MARK_LOW the block drives the line low. ST_MARK_GAP is the released phase of the marker. ST_IDLE waits for a start bit while the flag is clear. ST_SEL takes the register-select bit, ST_DATA shifts in the twelve data bits, and ST_STOP checks the stop bit.

The transitions are:
- Reset or a brown-out request goes to ST_MARK_LOW from any state.
- ST_MARK_LOW goes to ST_MARK_GAP after its count of strobes.
- ST_MARK_GAP goes back to ST_MARK_LOW after its count of strobes if no start bit is seen.
- A strobe with the line low goes to ST_SEL from ST_MARK_GAP or from ST_IDLE.
- ST_SEL goes to ST_DATA on the next strobe.
- ST_DATA goes to ST_STOP after the twelfth data strobe.
- ST_STOP goes to ST_IDLE when the stop bit is zero (the frame is committed).
- ST_STOP goes to ST_MARK_LOW or ST_IDLE, depending on the flag, when the stop bit is one (the frame is dropped).

Top module: `cfg_wire_loader`

## Requirements
- R1: After `rst_n` is asserted, or in the clock after `por_req` is high, `mode_reg` equals 12'h199, `limit_reg` equals 12'h398 and `marker_flag` is 1.
- R2: A frame is one start strobe with the line at 0, one select strobe, then twelve data strobes placed into register bits 11 down to 0 in that order, then a stop strobe with the line at 0. The written register shows the new value in the clock after the stop strobe, and not before it.
- R3: A select bit of 1 writes `mode_reg` and leaves `limit_reg` unchanged.
- R4: A select bit of 0 writes `limit_reg` and leaves `mode_reg` unchanged.
- R5: A frame whose stop bit is 1 is dropped, and both registers keep their values.
- R6: While no frame is in progress, a strobe with the line at 1 is not a start bit and changes no register.
- R7: `marker_flag` clears in the clock after the first committed frame. A dropped frame leaves it set.
- R8: While `marker_flag` is 1 and no frame is in progress, `line_oe` is 1 for 2 strobes and then 0 for 4 strobes, and this repeats. `line_oe` is 0 during frame reception and whenever `marker_flag` is 0.
- R9: Strobes that occur while the block drives the line low are ignored as frame bits, even when the line reads 0.
- R10: A `por_req` in the middle of a frame aborts the frame, restores the defaults and sets `marker_flag`.
- R11: Layout of `mode_reg`: [11:10] baud range, [9:8] bit-check count, [7] modulation (1 = ASK), [6:2] sleep code, [1] sleep extension, [0] noise-disable.
- R12: Layout of `limit_reg`: [11:6] lower limit, [5:0] upper limit.
- R13: The default field values are baud 0, check count 1, ASK, sleep code 6, no sleep extension, noise suppression on (noise-disable = 1), lower limit 14 and upper limit 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| por_req | input | 1 | Synchronous brown-out reset request |
| line_in | input | 1 | Sampled level of the shared data line |
| bit_stb | input | 1 | One-clock strobe marking a line bit sample |
| mode_reg | output | 12 | Operating-mode register contents |
| limit_reg | output | 12 | Limit register contents |
| line_oe | output | 1 | Enable for pulling the data line low |
| marker_flag | output | 1 | Set while the contents are the post-reset defaults |

## Verification
Frames are sent with each select value, and each write is checked against the register that was not addressed, which tells apart a correct write from a write to the wrong register. A frame with a bad stop bit shows whether the block commits before the stop bit is checked. Low line levels during the drive phase of the marker, followed by a real frame, show whether the block ignores strobes while it drives the line itself; if it did not, the data would land misaligned. Idle strobes with the line high, and a brown-out request in the middle of a frame, separate a true start-bit detector and a true abort from a free-running bit counter.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MARK_LOW,
        ST_MARK_GAP,
        ST_SEL,
        ST_DATA,
        ST_STOP
    } ld_state_t;

    typedef struct packed {
        logic [1:0] baud;
        logic [1:0] chk_cnt;
        logic       ask_mod;
        logic [4:0] sleep_code;
        logic       sleep_ext;
        logic       noise_dis;
    } mode_fields_t;

    typedef struct packed {
        logic [5:0] lo_lim;
        logic [5:0] hi_lim;
    } limit_fields_t;

    localparam int CFG_W = $bits(mode_fields_t);

    localparam mode_fields_t MODE_RST = '{
        baud:       2'd0,
        chk_cnt:    2'd1,
        ask_mod:    1'b1,
        sleep_code: 5'd6,
        sleep_ext:  1'b0,
        noise_dis:  1'b1
    };

    localparam limit_fields_t LIMIT_RST = '{
        lo_lim: 6'd14,
        hi_lim: 6'd24
    };

endpackage

// File: rtl/cfg_frame_shift.sv
module cfg_frame_shift #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [DATA_W-1:0] data,
    output logic              last
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (shift_en) begin
            cnt_q <= cnt_q + 1'b1;
            sh_q  <= {sh_q[DATA_W-2:0], bit_in};
        end
    end

    assign data = sh_q;
    assign last = (cnt_q == LAST_IDX);
endmodule

// File: rtl/cfg_marker_timer.sv
module cfg_marker_timer #(
    parameter int LOW_N = 2,
    parameter int GAP_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic low_done,
    output logic gap_done
);
    localparam int MAX_N = (LOW_N > GAP_N) ? LOW_N : GAP_N;
    localparam int CNT_W = $clog2(MAX_N + 1);
    localparam logic [CNT_W-1:0] LOW_LAST = CNT_W'(LOW_N - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_N - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign low_done = tick && (cnt_q == LOW_LAST);
    assign gap_done = tick && (cnt_q == GAP_LAST);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_loader_pkg::*;
#(
    parameter int DATA_W = CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_defaults,
    input  logic              commit,
    input  logic              sel_mode,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] limit_q,
    output logic              flag_q
);
    localparam int NREG = 2;

    logic [NREG-1:0][DATA_W-1:0] rst_val;
    logic [NREG-1:0][DATA_W-1:0] regs_q;
    logic [NREG-1:0]             hit;

    assign rst_val[0] = DATA_W'(MODE_RST);
    assign rst_val[1] = DATA_W'(LIMIT_RST);
    assign hit[0]     = sel_mode;
    assign hit[1]     = !sel_mode;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= rst_val[g];
            end else if (load_defaults) begin
                regs_q[g] <= rst_val[g];
            end else if (commit && hit[g]) begin
                regs_q[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b1;
        end else if (load_defaults) begin
            flag_q <= 1'b1;
        end else if (commit) begin
            flag_q <= 1'b0;
        end
    end

    assign mode_q  = regs_q[0];
    assign limit_q = regs_q[1];
endmodule

// File: rtl/cfg_wire_loader.sv
module cfg_wire_loader
    import cfg_loader_pkg::*;
#(
    parameter int MARK_LOW_STB = 2,
    parameter int MARK_GAP_STB = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_req,
    input  logic             line_in,
    input  logic             bit_stb,
    output logic [CFG_W-1:0] mode_reg,
    output logic [CFG_W-1:0] limit_reg,
    output logic             line_oe,
    output logic             marker_flag
);
    ld_state_t state_q, state_d;

    logic             sel_q;
    logic             low_done, gap_done;
    logic             tmr_clr, tmr_tick;
    logic             sh_clr, sh_en, sh_last;
    logic             commit;
    logic [CFG_W-1:0] sh_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_MARK_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (state_q == ST_SEL && bit_stb) begin
            sel_q <= line_in;
        end
    end

    always_comb begin
        state_d = state_q;
        if (por_req) begin
            state_d = ST_MARK_LOW;
        end else if (bit_stb) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!line_in) state_d = ST_SEL;
                end
                ST_MARK_LOW: begin
                    if (low_done) state_d = ST_MARK_GAP;
                end
                ST_MARK_GAP: begin
                    if (!line_in)      state_d = ST_SEL;
                    else if (gap_done) state_d = ST_MARK_LOW;
                end
                ST_SEL: begin
                    state_d = ST_DATA;
                end
                ST_DATA: begin
                    if (sh_last) state_d = ST_STOP;
                end
                ST_STOP: begin
                    if (!line_in)         state_d = ST_IDLE;
                    else if (marker_flag) state_d = ST_MARK_LOW;
                    else                  state_d = ST_IDLE;
                end
                default: state_d = ST_MARK_LOW;
            endcase
        end
    end

    always_comb begin
        line_oe  = 1'b0;
        tmr_tick = 1'b0;
        sh_clr   = 1'b0;
        sh_en    = 1'b0;
        commit   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_MARK_LOW: begin
                line_oe  = 1'b1;
                tmr_tick = bit_stb;
            end
            ST_MARK_GAP: begin
                tmr_tick = bit_stb;
            end
            ST_SEL: begin
                sh_clr = bit_stb;
            end
            ST_DATA: begin
                sh_en = bit_stb;
            end
            ST_STOP: begin
                commit = bit_stb && !line_in && !por_req;
            end
            default: ;
        endcase
        tmr_clr = por_req || (state_d != state_q);
    end

    cfg_marker_timer #(
        .LOW_N (MARK_LOW_STB),
        .GAP_N (MARK_GAP_STB)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tmr_clr),
        .tick     (tmr_tick),
        .low_done (low_done),
        .gap_done (gap_done)
    );

    cfg_frame_shift #(
        .DATA_W (CFG_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sh_clr),
        .shift_en (sh_en),
        .bit_in   (line_in),
        .data     (sh_data),
        .last     (sh_last)
    );

    cfg_reg_bank #(
        .DATA_W (CFG_W)
    ) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_defaults (por_req),
        .commit        (commit),
        .sel_mode      (sel_q),
        .wdata         (sh_data),
        .mode_q        (mode_reg),
        .limit_q       (limit_reg),
        .flag_q        (marker_flag)
    );
endmodule

// File: rtl/cfg_wire_loader_chk.sv
module cfg_wire_loader_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         por_req,
    input logic         line_in,
    input logic         bit_stb,
    input logic [W-1:0] mode_reg,
    input logic [W-1:0] limit_reg,
    input logic         line_oe,
    input logic         marker_flag
);
    localparam logic [W-1:0] MODE_DEF  = W'(12'h199);
    localparam logic [W-1:0] LIMIT_DEF = W'(12'h398);

    p_defaults_r1: assert property (@(posedge clk) disable iff (!rst_n)
        por_req |=> (marker_flag && mode_reg == MODE_DEF && limit_reg == LIMIT_DEF));

    p_mode_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_reg != $past(mode_reg)) && !$past(por_req)) |-> ($past(bit_stb) && !$past(line_in)));

    p_limit_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((limit_reg != $past(limit_reg)) && !$past(por_req)) |-> ($past(bit_stb) && !$past(line_in)));

    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(marker_flag) |-> ($past(bit_stb) && !$past(line_in)));

    p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(marker_flag) |-> $past(por_req));

    p_oe_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe |-> marker_flag);

    p_oe_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bit_stb) && !$past(por_req)) |-> $stable(line_oe));
endmodule

bind cfg_wire_loader cfg_wire_loader_chk #(.W(12)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_req     (por_req),
    .line_in     (line_in),
    .bit_stb     (bit_stb),
    .mode_reg    (mode_reg),
    .limit_reg   (limit_reg),
    .line_oe     (line_oe),
    .marker_flag (marker_flag)
);

// File: tb/cfg_wire_loader_tb.sv
module cfg_wire_loader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] MODE_DEF  = 12'h199;
    localparam logic [11:0] LIMIT_DEF = 12'h398;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_req = 1'b0;
    logic        line_in = 1'b1;
    logic        bit_stb = 1'b0;
    logic [11:0] mode_reg, limit_reg;
    logic        line_oe, marker_flag;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_wire_loader dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .por_req     (por_req),
        .line_in     (line_in),
        .bit_stb     (bit_stb),
        .mode_reg    (mode_reg),
        .limit_reg   (limit_reg),
        .line_oe     (line_oe),
        .marker_flag (marker_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic stb(input logic v);
        @(negedge clk);
        line_in = v;
        bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        line_in = 1'b1;
    endtask

    task automatic frame_body(input logic sel, input logic [11:0] d);
        stb(1'b0);
        stb(sel);
        for (int i = 11; i >= 0; i--) stb(d[i]);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mode default", mode_reg, MODE_DEF);
        check("R1 limit default", limit_reg, LIMIT_DEF);
        check("R1 flag set", marker_flag, 1);
        check("R8 oe at marker start", line_oe, 1);
        check("R11 baud field", mode_reg[11:10], 0);
        check("R11 R13 check count field", mode_reg[9:8], 1);
        check("R11 R13 ask field", mode_reg[7], 1);
        check("R11 R13 sleep field", mode_reg[6:2], 6);
        check("R11 R13 ext and noise-disable", mode_reg[1:0], 2'b01);
        check("R12 R13 lower limit", limit_reg[11:6], 14);
        check("R12 R13 upper limit", limit_reg[5:0], 24);
    endtask

    task automatic t_marker_pattern();
        stb(1'b1);
        check("R8 oe after 1 low strobe", line_oe, 1);
        stb(1'b1);
        check("R8 oe released after 2", line_oe, 0);
        for (int i = 0; i < 3; i++) stb(1'b1);
        check("R8 oe still released", line_oe, 0);
        stb(1'b1);
        check("R8 oe driven again after 4 gap", line_oe, 1);
    endtask

    task automatic t_bad_stop();
        stb(1'b1);
        stb(1'b1);
        frame_body(1'b1, 12'h123);
        stb(1'b1);
        check("R5 mode kept", mode_reg, MODE_DEF);
        check("R5 limit kept", limit_reg, LIMIT_DEF);
        check("R7 flag kept after drop", marker_flag, 1);
        check("R8 marker resumes", line_oe, 1);
    endtask

    task automatic t_marker_ignore();
        stb(1'b0);
        stb(1'b0);
        check("R9 gap after low-phase zeros", line_oe, 0);
        stb(1'b0);
        check("R8 oe off in frame", line_oe, 0);
        stb(1'b1);
        for (int i = 11; i >= 0; i--) stb(logic'(12'hA5C >> i));
        check("R2 not written before stop", mode_reg, MODE_DEF);
        stb(1'b0);
        check("R9 R3 mode written", mode_reg, 12'hA5C);
        check("R3 limit untouched", limit_reg, LIMIT_DEF);
        check("R7 flag cleared", marker_flag, 0);
        check("R8 oe off with flag clear", line_oe, 0);
    endtask

    task automatic t_limit_write();
        frame_body(1'b0, 12'h2D7);
        stb(1'b0);
        check("R4 limit written", limit_reg, 12'h2D7);
        check("R4 mode untouched", mode_reg, 12'hA5C);
    endtask

    task automatic t_idle_high();
        for (int i = 0; i < 5; i++) stb(1'b1);
        check("R6 mode after idle", mode_reg, 12'hA5C);
        check("R6 limit after idle", limit_reg, 12'h2D7);
        frame_body(1'b1, 12'h3F0);
        stb(1'b0);
        check("R6 R2 aligned frame after idle", mode_reg, 12'h3F0);
    endtask

    task automatic t_por_abort();
        stb(1'b0);
        stb(1'b1);
        for (int i = 0; i < 5; i++) stb(1'b0);
        @(negedge clk);
        por_req = 1'b1;
        @(negedge clk);
        por_req = 1'b0;
        check("R10 mode default", mode_reg, MODE_DEF);
        check("R10 limit default", limit_reg, LIMIT_DEF);
        check("R10 flag set", marker_flag, 1);
        check("R10 R1 marker driving", line_oe, 1);
    endtask

    initial begin
        t_reset();
        t_marker_pattern();
        t_bad_stop();
        t_marker_ignore();
        t_limit_write();
        t_idle_high();
        t_por_abort();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule